// File: doc/BRIEF.md
# Peripheral Chip-Select and Strobe Sequencer

This block runs a single read or write access on a simple microprocessor-style peripheral port. The port has an active-low chip enable, an active-low output enable and an active-low write enable. The sequencer runs in the peripheral clock domain. Its inputs are read and write request levels that are already synchronized to that clock, together with a held address and held write data. It starts an access when it sees a rising edge on one of the request levels.

Every access walks the same fixed phases, one clock each. First the chip is selected. Next comes the direction strobe: output enable for a read, write enable for a write. A completion phase follows, in which a one-cycle done pulse is raised, and then a phase that releases the chip select. After that the sequencer is idle again. A read latches the peripheral data at the end of its strobe phase. A write drives the data bus from the select phase through the completion phase. All outputs come straight from flip-flops clocked by the peripheral clock.

Top module: `pstrobe_seq`

## Requirements
- R1: While reset is asserted and right after it is released, cs_n, rd_n and wr_n are 1, done and bus_oe are 0, and rdata, bus_addr and bus_wdata are 0.
- R2: An access starts only on a rising edge (0 in the previous clock, 1 now) of rd_req or wr_req while the sequencer is idle. A request level that stays high starts no second access.
- R3: An access that starts at clock edge k has exactly this phase order: select after edge k, strobe after k+1, completion after k+2, release after k+3, idle after k+4.
- R4: cs_n is 0 in the select, strobe and completion phases and 1 in the release phase and in idle.
- R5: rd_n is 0 only in the strobe phase of a read and wr_n is 0 only in the strobe phase of a write. rd_n and wr_n are never 0 in the same cycle.
- R6: A read loads bus_rdata into rdata on the clock edge that ends the strobe phase. rdata then holds that value until the next read loads it again.
- R7: A write drives bus_oe to 1 in the select, strobe and completion phases, with bus_wdata equal to wdata as sampled at the starting edge. bus_oe stays 0 during reads and in idle.
- R8: bus_addr takes the value of addr at the starting edge and stays at that value through the whole access.
- R9: done is 1 for exactly one cycle per access, during the completion phase, while cs_n is still 0.
- R10: A request edge that arrives in any phase other than idle is ignored. It starts no access, either at once or later.
- R11: When rd_req and wr_req rise at the same edge in idle, the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Synchronized read request level |
| wr_req | input | 1 | Synchronized write request level |
| addr | input | AW | Access address, held by the requester |
| wdata | input | DW | Write data, held by the requester |
| bus_rdata | input | DW | Data returned by the peripheral |
| bus_addr | output | AW | Address driven to the peripheral |
| bus_wdata | output | DW | Write data driven to the peripheral |
| bus_oe | output | 1 | Drive enable for the peripheral data bus |
| cs_n | output | 1 | Chip enable, active low |
| rd_n | output | 1 | Output enable, active low |
| wr_n | output | 1 | Write enable, active low |
| rdata | output | DW | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a request edge that lands while an access is under way, most of all in the release phase. At that point cs_n is already high, so from the ports the sequencer looks almost idle. Directed tests raise a second request during the strobe phase and also during the release phase, then watch several idle cycles to confirm that no access follows. The random transactions use request levels of different lengths. Some of these levels are still high when the access ends, which tests that a held level does not restart the sequencer.

// File: rtl/pstrobe_pkg.sv
package pstrobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SEL     = 3'd1,
    PH_RDSTB   = 3'd2,
    PH_WRSTB   = 3'd3,
    PH_FINISH  = 3'd4,
    PH_RELEASE = 3'd5
  } phase_e;

  localparam int unsigned REQ_CH = 2;
  localparam int unsigned CH_RD  = 0;
  localparam int unsigned CH_WR  = 1;

  function automatic logic sel_active(phase_e p);
    return (p == PH_SEL) || (p == PH_RDSTB) || (p == PH_WRSTB) || (p == PH_FINISH);
  endfunction

endpackage

// File: rtl/pstrobe_edge.sv
module pstrobe_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/pstrobe_fsm.sv
module pstrobe_fsm
  import pstrobe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rd_rise,
  input  logic   wr_rise,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   start,
  output logic   is_rd_d
);

  logic is_rd_q;

  assign start   = (phase_q == PH_IDLE) && (rd_rise || wr_rise);
  assign is_rd_d = start ? rd_rise : is_rd_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start) phase_d = PH_SEL;
      PH_SEL:     phase_d = is_rd_q ? PH_RDSTB : PH_WRSTB;
      PH_RDSTB:   phase_d = PH_FINISH;
      PH_WRSTB:   phase_d = PH_FINISH;
      PH_FINISH:  phase_d = PH_RELEASE;
      PH_RELEASE: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      is_rd_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start) is_rd_q <= rd_rise;
    end
  end

  // A started access always enters the select phase next
  assert_start_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == PH_SEL));

  // Release is always followed by idle
  assert_release_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RELEASE) |=> (phase_q == PH_IDLE));

  // Edges outside idle do not disturb the phase walk
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FINISH && (rd_rise || wr_rise)) |=> (phase_q == PH_RELEASE));

endmodule

// File: rtl/pstrobe_io.sv
module pstrobe_io
  import pstrobe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_q,
  input  phase_e        phase_d,
  input  logic          start,
  input  logic          is_rd_d,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_oe,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);

  logic cs_n_d, rd_n_d, wr_n_d, oe_d, done_d;
  logic cap_en;

  always_comb begin
    cs_n_d = !sel_active(phase_d);
    rd_n_d = (phase_d != PH_RDSTB);
    wr_n_d = (phase_d != PH_WRSTB);
    oe_d   = !is_rd_d && sel_active(phase_d);
    done_d = (phase_d == PH_FINISH);
    cap_en = (phase_q == PH_RDSTB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      bus_oe <= 1'b0;
      done   <= 1'b0;
    end else begin
      cs_n   <= cs_n_d;
      rd_n   <= rd_n_d;
      wr_n   <= wr_n_d;
      bus_oe <= oe_d;
      done   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (start) begin
      bus_addr  <= addr;
      bus_wdata <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= bus_rdata;
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_strobe_in_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs_n);

  assert_release_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(done));

  assert_write_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);

  assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$rose(!cs_n)) |-> $stable(bus_addr));

endmodule

// File: rtl/pstrobe_seq.sv
module pstrobe_seq
  import pstrobe_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_oe,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);

  logic [REQ_CH-1:0] req_lvl, req_rise;
  phase_e            phase_q, phase_d;
  logic              start, is_rd_d;

  assign req_lvl[CH_RD] = rd_req;
  assign req_lvl[CH_WR] = wr_req;

  pstrobe_edge #(.N(REQ_CH)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (req_lvl),
    .rise  (req_rise)
  );

  pstrobe_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_rise (req_rise[CH_RD]),
    .wr_rise (req_rise[CH_WR]),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .start   (start),
    .is_rd_d (is_rd_d)
  );

  pstrobe_io #(.AW(AW), .DW(DW)) u_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .start     (start),
    .is_rd_d   (is_rd_d),
    .addr      (addr),
    .wdata     (wdata),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_oe    (bus_oe),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rdata     (rdata),
    .done      (done)
  );

endmodule

// File: tb/pstrobe_seq_tb.sv
module pstrobe_seq_tb;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_req, wr_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rdata;
  logic          bus_oe, cs_n, rd_n, wr_n, done;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] last_rd;

  always #5 clk = ~clk;

  pstrobe_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .addr(addr), .wdata(wdata), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_oe(bus_oe),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected pins per phase index (1=select,2=strobe,3=finish,4=release,5=idle)
  function automatic logic [4:0] exp_pins(int ph, bit rd);
    logic c, r, w, o, d;
    c = !(ph >= 1 && ph <= 3);
    r = !(ph == 2 && rd);
    w = !(ph == 2 && !rd);
    o = !rd && (ph >= 1 && ph <= 3);
    d = (ph == 3);
    return {c, r, w, o, d};
  endfunction

  task automatic idle_check(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, {27'd0, cs_n, rd_n, wr_n, bus_oe, done}, {27'd0, 5'b11100});
    end
  endtask

  // One access; hold_len = negedge index at which the request(s) drop.
  // late = 0 none, 2 = extra write edge in strobe, 4 = extra edge in release
  task automatic access(input bit do_rd, input bit do_wr, input int hold_len, input int late);
    bit rd_exp;
    logic [AW-1:0] a;
    logic [DW-1:0] wd, pd;
    a  = AW'($urandom);
    wd = DW'($urandom);
    pd = DW'($urandom);
    rd_exp = do_rd;
    @(negedge clk);
    addr = a; wdata = wd; bus_rdata = pd;
    rd_req = do_rd; wr_req = do_wr;
    for (int ph = 1; ph <= 5; ph++) begin
      @(negedge clk);
      chk("R3/R4/R5/R9 pins", {27'd0, cs_n, rd_n, wr_n, bus_oe, done},
          {27'd0, exp_pins(ph, rd_exp)});
      if (ph <= 3) chk("R8 address", 32'(bus_addr), 32'(a));
      if (ph <= 3 && !rd_exp) chk("R7 write data", 32'(bus_wdata), 32'(wd));
      if (ph == 3) begin
        if (rd_exp) begin
          chk("R6 capture", 32'(rdata), 32'(pd));
          last_rd = pd;
        end else begin
          chk("R6 hold on write", 32'(rdata), 32'(last_rd));
        end
        bus_rdata = ~pd;
        addr = ~a;
        wdata = ~wd;
      end
      if (ph == 4) chk("R6 hold", 32'(rdata), 32'(last_rd));
      if (ph == hold_len) begin rd_req = 1'b0; wr_req = 1'b0; end
      if (late != 0 && ph == late) wr_req = 1'b1;
      if (late != 0 && ph == late + 1 && hold_len <= late) wr_req = 1'b0;
    end
    rd_req = 1'b0; wr_req = 1'b0;
    idle_check("R2/R10 no restart", 2);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rd_req = 0; wr_req = 0; addr = '0; wdata = '0; bus_rdata = '0;
    last_rd = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", {27'd0, cs_n, rd_n, wr_n, bus_oe, done}, {27'd0, 5'b11100});
    rst_n = 1;
    @(negedge clk);
    chk("R1 pins after reset", {27'd0, cs_n, rd_n, wr_n, bus_oe, done}, {27'd0, 5'b11100});
    chk("R1 registers", {bus_addr, rdata}, 32'd0);
    chk("R1 write data", 32'(bus_wdata), 32'd0);

    // Directed corners
    access(1'b1, 1'b0, 1, 0);  // R3 short read
    access(1'b0, 1'b1, 1, 0);  // R7 short write
    access(1'b1, 1'b1, 2, 0);  // R11 read wins
    access(1'b1, 1'b0, 6, 0);  // R2 level held past end
    access(1'b1, 1'b0, 1, 2);  // R10 edge during strobe
    access(1'b0, 1'b1, 1, 4);  // R10 edge during release

    // Random traffic
    for (int t = 0; t < 60; t++) begin
      int k;
      k = int'($urandom_range(0, 2));
      access(k != 1, k != 0, int'($urandom_range(1, 6)), 0);
      repeat (int'($urandom_range(0, 2))) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule